// File: doc/BRIEF.md
# Serial Channel Status and Receive Interrupt Unit

This block holds the status flags of one asynchronous serial channel and turns them into a receive interrupt request. The receive and transmit datapaths report events to it as one-cycle pulses: a parity mismatch, a bad stop bit, and the hand-over of the transmit holding byte to the shift register. The receiver's full and overrun flags arrive as levels. Two external pins enter through synchronizers. The carrier-detect pin is high when there is no carrier. The clear-to-send pin is high when the far end is not ready.

The CPU reads one status byte and may write only its interrupt-enable bit. Both error flags clear from several sources: an error-reset strobe from the control logic, the carrier-detect pin being high, I/O stop mode, and reset. A carrier-detect bit is latched so that software sees a lost carrier, and the rising edge of the carrier-detect pin raises a pending interrupt. While the synchronized carrier-detect level is high, the receiver is held in reset.

Top module: `ser_stat_irq`

## Requirements
- R1: A parity pulse `par_err_p_i` sets the parity error flag (status bit 5) only when `par_chk_en_i` is 1 in the same cycle. Otherwise the flag is unchanged.
- R2: A stop-bit pulse `stop_err_p_i` sets the framing error flag (status bit 4) on the next clock edge.
- R3: Both error flags clear on the edge after any of these holds: `err_clr_i` is 1, `stop_i` is 1, or the synchronized carrier-detect level is high. Reset also clears them. A clear wins over a set pulse in the same cycle.
- R4: `rx_irq_o` is a combinational level equal to interrupt-enable AND (`rx_full_i` OR `overrun_i` OR parity error OR framing error OR pending carrier edge).
- R5: A rising edge of the synchronized carrier-detect level sets a pending carrier event. A status read (`stat_rd_i`) clears it on the next edge. A rise wins over a read in the same cycle.
- R6: `rx_rst_o` equals the synchronized carrier-detect level.
- R7: A CPU write to the transmit register (`tdr_wr_i`) clears the transmit-empty state. A `tx_load_p_i` pulse sets it. If both occur in the same cycle, the write wins.
- R8: `stop_i` sets the transmit-empty state and wins over a write. Status bit 1 reads as the transmit-empty state AND NOT the synchronized clear-to-send level.
- R9: Status bit 2 is set while synchronized carrier-detect is high. Once carrier-detect is low, the bit stays set until the first status read, and clears on the edge of that read.
- R10: The status byte carries parity error at bit 5, framing error at bit 4, interrupt enable at bit 3, carrier-detect at bit 2 and transmit-empty at bit 1; bits 7, 6 and 0 read 0. A status write (`stat_wr_i`) loads only bit 3 from `stat_wdata_i[3]`.
- R11: After reset, `stat_o` is 8'h02, and `rx_irq_o` and `rx_rst_o` are 0.
- R12: Each pin passes through two flip-flops. A pin change is seen on `rx_rst_o` or on status bit 1 after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | I/O stop mode |
| par_chk_en_i | input | 1 | Parity checking enabled |
| err_clr_i | input | 1 | Error-flag reset strobe |
| par_err_p_i | input | 1 | Parity mismatch pulse |
| stop_err_p_i | input | 1 | Bad stop bit pulse |
| rx_full_i | input | 1 | Receive data full level |
| overrun_i | input | 1 | Overrun level |
| tx_load_p_i | input | 1 | Holding byte moved to shift register |
| tdr_wr_i | input | 1 | CPU write of transmit data register |
| stat_rd_i | input | 1 | CPU read of status register |
| stat_wr_i | input | 1 | CPU write of status register |
| stat_wdata_i | input | 8 | Status write data |
| dcd_pin_i | input | 1 | Carrier-detect pin, high means no carrier |
| cts_pin_i | input | 1 | Clear-to-send pin, high means not ready |
| stat_o | output | 8 | Status byte |
| rx_irq_o | output | 1 | Receive interrupt request |
| rx_rst_o | output | 1 | Receiver reset and inhibit |

## Verification
Several pairs of events can land in the same cycle, and the bench provokes each pair at once. An error pulse can coincide with a clear source, either the clear strobe or stop mode. A transmit register write can coincide with a shift-register load. A status read can coincide with a carrier-detect rising edge. For each pair, the bench drives both inputs in one cycle from the vector table or a directed step. It then reads the status byte and the interrupt one edge later and compares them with the stated winner: the clear, the write, and the rise.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned SYNC_N   = 2;
  localparam int unsigned BIT_PE   = 5;
  localparam int unsigned BIT_FE   = 4;
  localparam int unsigned BIT_RIE  = 3;
  localparam int unsigned BIT_DCD  = 2;
  localparam int unsigned BIT_TDRE = 1;
  localparam int unsigned NUM_ERR  = 2;
  localparam int unsigned ERR_PAR  = 0;
  localparam int unsigned ERR_FRM  = 1;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssi_err.sv
module ssi_err #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[i] <= 1'b0;
      else if (clr_i) flag_o[i] <= 1'b0;   // clear wins over set
      else if (set_i[i]) flag_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/ssi_carrier.sv
module ssi_carrier (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dcd_s_i,
  input  logic rd_i,
  output logic dcd_bit_o,
  output logic pend_o
);
  logic dcd_d_q;
  logic rise;

  assign rise = dcd_s_i & ~dcd_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcd_d_q   <= 1'b0;
      dcd_bit_o <= 1'b0;
      pend_o    <= 1'b0;
    end else begin
      dcd_d_q <= dcd_s_i;
      if (dcd_s_i) dcd_bit_o <= 1'b1;
      else if (rd_i) dcd_bit_o <= 1'b0;
      if (rise) pend_o <= 1'b1;        // rise wins over read
      else if (rd_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ssi_tx_empty.sv
module ssi_tx_empty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic wr_i,
  input  logic load_i,
  input  logic cts_s_i,
  output logic empty_o
);
  logic empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_q <= 1'b1;
    else if (stop_i) empty_q <= 1'b1;
    else if (wr_i) empty_q <= 1'b0;    // new byte lands as old one leaves
    else if (load_i) empty_q <= 1'b1;
  end

  assign empty_o = empty_q & ~cts_s_i;
endmodule

// File: rtl/ser_stat_irq.sv
module ser_stat_irq
  import ssi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              par_chk_en_i,
  input  logic              err_clr_i,
  input  logic              par_err_p_i,
  input  logic              stop_err_p_i,
  input  logic              rx_full_i,
  input  logic              overrun_i,
  input  logic              tx_load_p_i,
  input  logic              tdr_wr_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  input  logic              dcd_pin_i,
  input  logic              cts_pin_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              rx_irq_o,
  output logic              rx_rst_o
);
  logic [1:0]         pin_s;
  logic               dcd_s;
  logic               cts_s;
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_flag;
  logic               rie_q;
  logic               dcd_bit;
  logic               dcd_pend;
  logic               tdre;
  logic               wdata_unused;

  assign wdata_unused = ^{stat_wdata_i[STAT_W-1:BIT_RIE+1], stat_wdata_i[BIT_RIE-1:0]};

  ssi_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cts_pin_i, dcd_pin_i}),
    .q_o   (pin_s)
  );
  assign dcd_s = pin_s[0];
  assign cts_s = pin_s[1];

  assign err_set[ERR_PAR] = par_err_p_i & par_chk_en_i;
  assign err_set[ERR_FRM] = stop_err_p_i;

  ssi_err #(.N(NUM_ERR)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (err_clr_i | stop_i | dcd_s),
    .set_i (err_set),
    .flag_o(err_flag)
  );

  ssi_carrier u_car (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dcd_s_i  (dcd_s),
    .rd_i     (stat_rd_i),
    .dcd_bit_o(dcd_bit),
    .pend_o   (dcd_pend)
  );

  ssi_tx_empty u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stop_i (stop_i),
    .wr_i   (tdr_wr_i),
    .load_i (tx_load_p_i),
    .cts_s_i(cts_s),
    .empty_o(tdre)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rie_q <= 1'b0;
    else if (stat_wr_i) rie_q <= stat_wdata_i[BIT_RIE];
  end

  always_comb begin
    stat_o           = '0;
    stat_o[BIT_PE]   = err_flag[ERR_PAR];
    stat_o[BIT_FE]   = err_flag[ERR_FRM];
    stat_o[BIT_RIE]  = rie_q;
    stat_o[BIT_DCD]  = dcd_bit;
    stat_o[BIT_TDRE] = tdre;
  end

  assign rx_irq_o = rie_q & (rx_full_i | overrun_i | err_flag[ERR_PAR]
                             | err_flag[ERR_FRM] | dcd_pend);
  assign rx_rst_o = dcd_s;
endmodule

// File: rtl/ssi_chk.sv
module ssi_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       par_chk_en_i,
  input logic       par_err_p_i,
  input logic       rx_full_i,
  input logic       overrun_i,
  input logic       tdr_wr_i,
  input logic       cts_s,
  input logic [7:0] stat_o,
  input logic       rx_irq_o,
  input logic       rx_rst_o
);
  AST_PE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(stat_o[5]) && stat_o[5]) |-> $past(par_err_p_i && par_chk_en_i)); // R1
  AST_STOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!stat_o[5] && !stat_o[4])); // R3
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[3] |-> !rx_irq_o); // R4
  AST_IRQ_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[3] && (rx_full_i || overrun_i || stat_o[5] || stat_o[4])) |-> rx_irq_o); // R4
  AST_RST_DCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o |=> stat_o[2]); // R6
  AST_TDR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tdr_wr_i && !stop_i) |=> !stat_o[1]); // R7
  AST_CTS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_s |-> !stat_o[1]); // R8
  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[7:6] == 2'b00) && !stat_o[0]); // R10
endmodule

bind ser_stat_irq ssi_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_i),
  .par_chk_en_i(par_chk_en_i),
  .par_err_p_i (par_err_p_i),
  .rx_full_i   (rx_full_i),
  .overrun_i   (overrun_i),
  .tdr_wr_i    (tdr_wr_i),
  .cts_s       (cts_s),
  .stat_o      (stat_o),
  .rx_irq_o    (rx_irq_o),
  .rx_rst_o    (rx_rst_o)
);

// File: tb/sim_ser_stat_irq.sv
module sim_ser_stat_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop, par_en, clr, par_p, stp_p, rxf, ovr, tx_ld, tdr_wr, rd, wr;
  logic [7:0] wdata;
  logic dcd_pin, cts_pin;
  logic [7:0] stat;
  logic irq, rx_rst;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ser_stat_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .par_chk_en_i(par_en),
    .err_clr_i(clr), .par_err_p_i(par_p), .stop_err_p_i(stp_p),
    .rx_full_i(rxf), .overrun_i(ovr), .tx_load_p_i(tx_ld), .tdr_wr_i(tdr_wr),
    .stat_rd_i(rd), .stat_wr_i(wr), .stat_wdata_i(wdata),
    .dcd_pin_i(dcd_pin), .cts_pin_i(cts_pin),
    .stat_o(stat), .rx_irq_o(irq), .rx_rst_o(rx_rst)
  );

  // [17]wr(FF/00 by [16]) [15]rd [14]par_en [13]par_p [12]stp_p [11]clr [10]stop
  // [9]tdr_wr [8]tx_ld [7]rxf [6]ovr [5:1]exp pe,fe,rie,dcd,tdre [0]exp irq
  localparam int NV = 19;
  localparam logic [17:0] VEC [NV] = '{
    18'b00_0_0_1_0_0_0_0_0_0_0_00001_0, // R1 parity ignored when disabled
    18'b00_0_1_1_0_0_0_0_0_0_0_10001_0, // R1 parity set
    18'b00_0_0_0_1_0_0_0_0_0_0_11001_0, // R2 framing set
    18'b11_0_0_0_0_0_0_0_0_0_0_11101_1, // R10 write FF loads only enable, R4
    18'b00_0_0_0_0_1_0_0_0_0_0_00101_0, // R3 clear strobe
    18'b00_0_0_0_0_0_0_0_0_1_0_00101_1, // R4 rx full
    18'b00_0_0_0_0_0_0_0_0_0_1_00101_1, // R4 overrun
    18'b00_0_0_0_0_0_0_1_0_0_0_00100_0, // R7 write clears empty
    18'b00_0_0_0_0_0_0_0_1_0_0_00101_0, // R7 load sets empty
    18'b00_0_0_0_0_0_0_1_1_0_0_00100_0, // R7 write wins over load
    18'b00_0_0_0_0_0_1_0_0_0_0_00101_0, // R8 stop sets empty
    18'b00_0_1_1_0_1_0_0_0_0_0_00101_0, // R3 clear wins over parity
    18'b00_0_1_1_0_0_1_0_0_0_0_00101_0, // R3 stop wins over parity
    18'b00_0_0_0_1_0_0_0_0_0_0_01101_1, // R2 framing with enable, R4
    18'b00_0_0_0_0_0_1_0_0_0_0_00101_0, // R3 stop clears framing
    18'b10_0_0_0_0_0_0_0_0_1_0_00001_0, // R4 enable off masks rx full
    18'b00_0_0_0_0_0_0_1_0_0_0_00000_0, // R7 write clears empty
    18'b11_0_0_0_0_0_0_0_0_0_0_00100_0, // R10 write FF does not set empty
    18'b00_0_0_0_0_0_0_0_1_0_0_00101_0  // R7 load sets empty
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {stop, par_en, clr, par_p, stp_p, rxf, ovr, tx_ld, tdr_wr, rd, wr} = '0;
    wdata = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    dcd_pin = 1'b0;
    cts_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 stat", stat, 8'h02);
    chk("R11 irq", {7'd0, irq}, 8'h00);
    chk("R11 rx_rst", {7'd0, rx_rst}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr = VEC[i][17]; wdata = VEC[i][16] ? 8'hFF : 8'h00;
      rd = VEC[i][15]; par_en = VEC[i][14]; par_p = VEC[i][13];
      stp_p = VEC[i][12]; clr = VEC[i][11]; stop = VEC[i][10];
      tdr_wr = VEC[i][9]; tx_ld = VEC[i][8]; rxf = VEC[i][7]; ovr = VEC[i][6];
      @(negedge clk);
      chk($sformatf("R10 vec%0d stat", i), stat, {2'b00, VEC[i][5:1], 1'b0});
      chk($sformatf("R4 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end
    idle();

    // enable on, parity flag set
    wr = 1'b1; wdata = 8'h08; par_en = 1'b1; par_p = 1'b1;
    @(negedge clk); idle();
    chk("R1 pre-carrier", stat, 8'h2A);

    // carrier lost: R12 latency, R6, R3, R5, R9
    dcd_pin = 1'b1;
    @(negedge clk);
    chk("R12 one edge", {7'd0, rx_rst}, 8'h00);
    @(negedge clk);
    chk("R6 rx_rst high", {7'd0, rx_rst}, 8'h01);
    @(negedge clk);
    chk("R3 R9 carrier clears err sets dcd", stat, 8'h0E);
    chk("R5 pending irq", {7'd0, irq}, 8'h01);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R5 read clears pending", {7'd0, irq}, 8'h00);
    chk("R9 bit held while pin high", stat, 8'h0E);

    dcd_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 rx_rst low", {7'd0, rx_rst}, 8'h00);
    chk("R9 latched after pin low", stat, 8'h0E);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R9 first read clears", stat, 8'h0A);

    // rise and read in the same cycle
    dcd_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R5 rise wins over read", {7'd0, irq}, 8'h01);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R5 later read clears", {7'd0, irq}, 8'h00);
    dcd_pin = 1'b0;
    repeat (3) @(negedge clk);
    rd = 1'b1; @(negedge clk); rd = 1'b0;

    // clear-to-send mask
    cts_pin = 1'b1;
    @(negedge clk);
    chk("R12 cts one edge", stat, 8'h0A);
    @(negedge clk);
    chk("R8 cts masks empty", stat, 8'h08);
    cts_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 empty returns", stat, 8'h0A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule